// File: doc/BRIEF.md
# Resolver Tracking Loop Back End

This block closes the digital half of a type-II angle tracking loop for a resolver or synchro front end. Each valid strobe delivers a signed 16-bit error sample, taken to be proportional to the sine of the difference between the true shaft angle and the angle the block currently holds. The sample first feeds an integrator, whose state is the tracked velocity. It then passes a lead term and a first-order lag. The lag output is summed into an oscillator accumulator. Each time that accumulator crosses a fixed threshold, a 16-bit up/down angle counter moves by one step. The direction of the step follows the sign of the accumulator.

Software picks the output resolution (10, 12, 14 or 16 bits) and one of two loop bandwidths while the block is running. A hold input freezes the angle presented to the host while the loop keeps tracking underneath. A busy flag reports recent counter motion. If the input moves faster than the loop can follow, the flag never falls, so a loop that is not settling stays visible.

Top module: `rdc_track_loop`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the integrator, lag state, accumulator and counter. After it, `angle_live`, `angle_out` and `velocity` are zero and `busy` is low.
- R2: While `err_vld` is low, `err_in` has no effect: `angle_live` and `velocity` hold their values.
- R3: Every valid sample adds `err_in`×4 (`bw_hi`=0) or `err_in`×16 (`bw_hi`=1) to a signed 24-bit integrator. The integrator saturates at +8388607 and −8388608 and never wraps.
- R4: `velocity` equals the integrator shifted right arithmetically by 8. It is then shifted right arithmetically by a further 16−bits, where `res_sel` 0/1/2/3 selects 10/12/14/16 bits.
- R5: The lead sum is the updated integrator plus `err_in`×8 (low band) or `err_in`×32 (high band). The lag state moves toward the lead sum by (sum − lag) arithmetically shifted right by 3 (low band) or by 2 (high band).
- R6: On every valid sample the updated lag state is added to a saturating accumulator. If the result is at least 262144, the counter steps up and 262144 is subtracted. If it is at most −262144, the counter steps down and 262144 is added. A valid sample moves the counter at most one step.
- R7: One step is 2^(16−bits) LSBs of the 16-bit angle word. The low 16−bits bits of `angle_live` always read zero.
- R8: `busy` is high exactly when a counter step occurred within the last 8 valid samples. After 8 consecutive valid samples without a step it goes low.
- R9: When the tracking demand exceeds one step per sample, the counter steps on every valid sample and `busy` never falls.
- R10: A clock edge with `hold_req` high leaves `angle_out` unchanged. After an edge with `hold_req` low, `angle_out` equals `angle_live`. Holding never stalls tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| err_vld | input | 1 | Error sample strobe |
| err_in | input | 16 | Signed demodulated error sample |
| res_sel | input | 2 | Resolution select: 0=10, 1=12, 2=14, 3=16 bits |
| bw_hi | input | 1 | Bandwidth select: 0 low, 1 high |
| hold_req | input | 1 | Freeze the host angle output |
| angle_live | output | 16 | Live tracked angle word |
| angle_out | output | 16 | Host angle, frozen while hold is requested |
| velocity | output | 16 | Signed velocity, scaled to the resolution |
| busy | output | 1 | Counter moved within the recent sample window |

## Verification
The bound checker watches several rules on every clock. It checks the hold freeze and the follow-through after release. It checks that idle strobes leave the outputs untouched, and that no sample moves the counter more than one step. It also checks that any counter motion raises `busy`, and that a saturated velocity cannot wrap. Only the bench scenarios can show the exact arithmetic. These include the integrator gain in each band and the resolution scaling of velocity. They also cover a single accumulator crossing with the busy flag falling after exactly eight quiet samples, and the spin condition in which the counter steps on every sample.

// File: rtl/rdc_track_loop.sv
module rdc_track_loop #(
  parameter int ERR_W    = 16,
  parameter int ANG_W    = 16,
  parameter int ACC_W    = 24,
  parameter int NCO_W    = 26,
  parameter int KI_LO    = 2,
  parameter int KI_HI    = 4,
  parameter int LEAD_LO  = 3,
  parameter int LEAD_HI  = 5,
  parameter int LAG_LO   = 3,
  parameter int LAG_HI   = 2,
  parameter int STEP_TH  = 262144,
  parameter int BUSY_WIN = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    err_vld,
  input  logic signed [ERR_W-1:0] err_in,
  input  logic [1:0]              res_sel,
  input  logic                    bw_hi,
  input  logic                    hold_req,
  output logic [ANG_W-1:0]        angle_live,
  output logic [ANG_W-1:0]        angle_out,
  output logic signed [ANG_W-1:0] velocity,
  output logic                    busy
);

  localparam int XW  = ACC_W + 2;
  localparam int QW  = $clog2(BUSY_WIN + 1);
  localparam logic signed [XW-1:0]  A_MAX = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [XW-1:0]  A_MIN = {3'b111, {(ACC_W-1){1'b0}}};
  localparam logic signed [NCO_W:0] N_MAX = {2'b00, {(NCO_W-1){1'b1}}};
  localparam logic signed [NCO_W:0] N_MIN = {2'b11, {(NCO_W-1){1'b0}}};
  localparam logic signed [NCO_W:0] TH    = (NCO_W+1)'(STEP_TH);
  localparam logic [QW-1:0]         QMAX  = QW'(BUSY_WIN);

  function automatic logic signed [XW-1:0] ext(input logic signed [ACC_W-1:0] v);
    return XW'(v);
  endfunction

  function automatic logic signed [ACC_W-1:0] sat_acc(input logic signed [XW-1:0] v);
    if (v > A_MAX) return A_MAX[ACC_W-1:0];
    if (v < A_MIN) return A_MIN[ACC_W-1:0];
    return v[ACC_W-1:0];
  endfunction

  logic signed [ACC_W-1:0] integ_q, lag_q;
  logic signed [NCO_W-1:0] nco_q;
  logic [ANG_W-1:0]        cnt_q, frz_q;
  logic [QW-1:0]           quiet_q;

  logic [4:0]              ki_sh, lead_sh, lag_sh;
  logic signed [XW-1:0]    err_x, lag_dif;
  logic signed [ACC_W-1:0] integ_d, lead_u, lag_d;
  logic signed [NCO_W:0]   nco_sum, nco_sat;
  logic signed [NCO_W-1:0] nco_d;
  logic                    step_up, step_dn;
  logic [2:0]              drop;
  logic [ANG_W-1:0]        mask, step, base, cnt_d;
  logic signed [ANG_W-1:0] vel_full;

  assign ki_sh   = bw_hi ? 5'(KI_HI)   : 5'(KI_LO);
  assign lead_sh = bw_hi ? 5'(LEAD_HI) : 5'(LEAD_LO);
  assign lag_sh  = bw_hi ? 5'(LAG_HI)  : 5'(LAG_LO);
  assign err_x   = XW'(err_in);

  assign integ_d = sat_acc(ext(integ_q) + (err_x <<< ki_sh));
  assign lead_u  = sat_acc(ext(integ_d) + (err_x <<< lead_sh));
  assign lag_dif = ext(lead_u) - ext(lag_q);
  assign lag_d   = sat_acc(ext(lag_q) + (lag_dif >>> lag_sh));

  assign nco_sum = (NCO_W+1)'(nco_q) + (NCO_W+1)'(lag_d);
  assign nco_sat = (nco_sum > N_MAX) ? N_MAX : (nco_sum < N_MIN) ? N_MIN : nco_sum;
  assign step_up = nco_sat >= TH;
  assign step_dn = nco_sat <= -TH;
  assign nco_d   = NCO_W'(step_up ? nco_sat - TH : step_dn ? nco_sat + TH : nco_sat);

  assign drop  = 3'd6 - {res_sel, 1'b0};
  assign mask  = {ANG_W{1'b1}} << drop;
  assign step  = ANG_W'(1) << drop;
  assign base  = cnt_q & mask;
  assign cnt_d = step_up ? base + step : step_dn ? base - step : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      lag_q   <= '0;
      nco_q   <= '0;
      cnt_q   <= '0;
      frz_q   <= '0;
      quiet_q <= QMAX;
    end else begin
      if (err_vld) begin
        integ_q <= integ_d;
        lag_q   <= lag_d;
        nco_q   <= nco_d;
        cnt_q   <= cnt_d;
        if (step_up || step_dn) quiet_q <= '0;
        else if (quiet_q < QMAX) quiet_q <= quiet_q + 1'b1;
      end
      if (!hold_req) frz_q <= (err_vld ? cnt_d : cnt_q) & mask;
    end
  end

  assign vel_full   = integ_q[ACC_W-1 -: ANG_W];
  assign velocity   = vel_full >>> drop;
  assign angle_live = base;
  assign angle_out  = frz_q;
  assign busy       = quiet_q < QMAX;

endmodule

// File: rtl/rdc_track_loop_chk.sv
module rdc_track_loop_chk #(
  parameter int ERR_W = 16,
  parameter int ANG_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    err_vld,
  input logic signed [ERR_W-1:0] err_in,
  input logic [1:0]              res_sel,
  input logic                    hold_req,
  input logic [ANG_W-1:0]        angle_live,
  input logic [ANG_W-1:0]        angle_out,
  input logic signed [ANG_W-1:0] velocity,
  input logic                    busy
);

  localparam logic signed [ANG_W-1:0] V_MAX = {1'b0, {(ANG_W-1){1'b1}}};
  localparam logic signed [ANG_W-1:0] V_MIN = {1'b1, {(ANG_W-1){1'b0}}};

  logic [ANG_W-1:0] stp;
  assign stp = ANG_W'(1) << (3'd6 - {res_sel, 1'b0});

  assert_hold_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    hold_req |=> $stable(angle_out)) else $error("hold did not freeze angle_out");

  assert_hold_follow_R10: assert property (@(posedge clk) disable iff (rst)
    !hold_req |=> (res_sel != $past(res_sel)) || (angle_out == angle_live))
    else $error("angle_out not following angle_live");

  assert_idle_no_effect_R2: assert property (@(posedge clk) disable iff (rst)
    !err_vld |=> (res_sel != $past(res_sel)) || ($stable(angle_live) && $stable(velocity)))
    else $error("outputs moved without a valid sample");

  assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
    err_vld |=> (res_sel != $past(res_sel)) || (angle_live == $past(angle_live)) ||
                (angle_live == $past(angle_live) + stp) || (angle_live == $past(angle_live) - stp))
    else $error("counter moved more than one step");

  assert_busy_on_step_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && (res_sel == $past(res_sel)) && (angle_live != $past(angle_live)) |-> busy)
    else $error("step without busy");

  assert_no_wrap_hi_R3: assert property (@(posedge clk) disable iff (rst)
    err_vld && (res_sel == 2'd3) && (velocity == V_MAX) && !err_in[ERR_W-1]
      |=> (res_sel != 2'd3) || (velocity == V_MAX))
    else $error("velocity wrapped at positive limit");

  assert_no_wrap_lo_R3: assert property (@(posedge clk) disable iff (rst)
    err_vld && (res_sel == 2'd3) && (velocity == V_MIN) && err_in[ERR_W-1]
      |=> (res_sel != 2'd3) || (velocity == V_MIN))
    else $error("velocity wrapped at negative limit");

endmodule

bind rdc_track_loop rdc_track_loop_chk #(.ERR_W(ERR_W), .ANG_W(ANG_W)) chk_i (
  .clk(clk), .rst(rst), .err_vld(err_vld), .err_in(err_in), .res_sel(res_sel),
  .hold_req(hold_req), .angle_live(angle_live), .angle_out(angle_out),
  .velocity(velocity), .busy(busy)
);

// File: tb/rdc_track_loop_tb_top.sv
module rdc_track_loop_tb_top;
  logic clk = 1'b0, rst = 1'b1, err_vld = 1'b0, bw_hi = 1'b0, hold_req = 1'b0;
  logic signed [15:0] err_in = '0;
  logic [1:0]         res_sel = 2'd3;
  logic [15:0]        angle_live, angle_out;
  logic signed [15:0] velocity;
  logic               busy;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rdc_track_loop dut_i (
    .clk(clk), .rst(rst), .err_vld(err_vld), .err_in(err_in), .res_sel(res_sel),
    .bw_hi(bw_hi), .hold_req(hold_req), .angle_live(angle_live), .angle_out(angle_out),
    .velocity(velocity), .busy(busy)
  );

  // fields: res_sel[19:18], bw_hi[17], err[16:1], upward[0]
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {2'd3, 1'b0, 16'h0800, 1'b1}, {2'd3, 1'b1, 16'hF800, 1'b0},
    {2'd2, 1'b0, 16'hF800, 1'b0}, {2'd2, 1'b1, 16'h0800, 1'b1},
    {2'd1, 1'b0, 16'h0800, 1'b1}, {2'd1, 1'b1, 16'hF800, 1'b0},
    {2'd0, 1'b0, 16'hF800, 1'b0}, {2'd0, 1'b1, 16'h0800, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic smp(input logic signed [15:0] e);
    err_in = e; err_vld = 1'b1;
    @(negedge clk);
    err_vld = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] r; logic b; logic signed [15:0] e; logic up;
    int stp, sa, vexp, bad_busy;
    logic [15:0] a0; logic signed [15:0] v0;

    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(angle_live == 0, "R1 angle_live", angle_live, 0);
    chk(angle_out == 0, "R1 angle_out", angle_out, 0);
    chk(velocity == 0, "R1 velocity", velocity, 0);
    chk(busy == 0, "R1 busy", busy, 0);

    // table walk: R3 R4 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      r = VEC[i][19:18]; b = VEC[i][17]; e = VEC[i][16:1]; up = VEC[i][0];
      do_reset();
      res_sel = r; bw_hi = b;
      repeat (40) smp(e);
      stp  = 1 << (6 - 2 * r);
      sa   = int'($signed(angle_live));
      vexp = (40 * int'(e) * (b ? 16 : 4)) / 256 / stp;
      if (up) chk(sa > 0 && sa <= 40 * stp, "R6 upward travel", sa, 40 * stp);
      else    chk(sa < 0 && sa >= -40 * stp, "R6 downward travel", sa, -40 * stp);
      chk((angle_live & 16'(stp - 1)) == 0, "R7 low bits zero", angle_live & 16'(stp - 1), 0);
      chk(velocity == 16'(vexp), "R4 R3 velocity", velocity, vexp);
      chk(busy == 1, "R8 busy while moving", busy, 1);
      chk(angle_out == angle_live, "R10 follow", angle_out, angle_live);
    end

    // R3 R4 single sample gains and scaling
    do_reset(); res_sel = 2'd3; bw_hi = 1'b0;
    smp(16'sd4096);
    chk(velocity == 16'sd64, "R3 low gain res16", velocity, 64);
    res_sel = 2'd1; #1;
    chk(velocity == 16'sd4, "R4 res12 scaling", velocity, 4);
    @(negedge clk);
    do_reset(); res_sel = 2'd0; bw_hi = 1'b1;
    smp(16'sd4096);
    chk(velocity == 16'sd4, "R3 high gain res10", velocity, 4);

    // R5 R6 R8 single crossing then quiet window
    do_reset(); res_sel = 2'd3; bw_hi = 1'b1;
    smp(16'sd24000);
    chk(angle_live == 1, "R6 first crossing", angle_live, 1);
    chk(busy == 1, "R8 busy after step", busy, 1);
    smp(-16'sd24000);
    chk(velocity == 0, "R3 integrator back to zero", velocity, 0);
    repeat (6) smp(16'sd0);
    chk(busy == 1, "R8 busy after 7 quiet", busy, 1);
    smp(16'sd0);
    chk(busy == 0, "R8 busy low after 8 quiet", busy, 0);
    chk(angle_live == 1, "R5 lead lag single step", angle_live, 1);

    // R9 spin: one step every sample, busy never falls
    do_reset(); res_sel = 2'd3; bw_hi = 1'b1;
    bad_busy = 0;
    for (int k = 0; k < 200; k++) begin
      smp(16'sd32767);
      if (!busy) bad_busy++;
    end
    chk(bad_busy == 0, "R9 busy stuck high", bad_busy, 0);
    chk(angle_live == 200, "R9 step per sample", angle_live, 200);
    chk(velocity == 16'sd32767, "R3 positive saturation", velocity, 32767);

    // R2 idle strobes ignored
    a0 = angle_live; v0 = velocity;
    err_in = 16'sd12345; err_vld = 1'b0;
    repeat (5) @(negedge clk);
    chk(angle_live == a0, "R2 angle held", angle_live, a0);
    chk(velocity == v0, "R2 velocity held", velocity, v0);

    // R10 hold freezes output while tracking continues
    hold_req = 1'b1;
    a0 = angle_out;
    repeat (5) smp(16'sd32767);
    chk(angle_out == a0, "R10 frozen", angle_out, a0);
    chk(angle_live == a0 + 16'd5, "R10 tracking continues", angle_live, a0 + 16'd5);
    hold_req = 1'b0;
    @(negedge clk);
    chk(angle_out == angle_live, "R10 resume", angle_out, angle_live);

    // R3 negative saturation
    repeat (60) smp(-16'sd32768);
    chk(velocity == -16'sd32768, "R3 negative saturation", velocity, -32768);

    // R1 reset mid-run
    do_reset();
    chk(angle_live == 0 && angle_out == 0, "R1 mid-run angle", angle_live, 0);
    chk(velocity == 0, "R1 mid-run velocity", velocity, 0);
    chk(busy == 0, "R1 mid-run busy", busy, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule